// File: doc/BRIEF.md
# Dual-Codec Serial Input Frame Decoder

This block receives the two serial input lines of an audio codec link, one from a primary codec and one from a secondary codec. It turns each line's 256-bit frame into a tag slot and twelve data slots, and it merges the two streams into one set of slot outputs. Both lines are deserialized in parallel against a shared frame counter. The counter is started by the rising edge of the frame sync input, and the logic runs on the bit clock.

The data slots of the two lines are combined on the assumption that no slot position carries valid data on both lines in the same frame. If both lines do flag the same slot, the primary line's data wins and a sticky error flag is raised. Each codec's ready flag is reported on its own output bit. The slot request bits carried in slot 1 are reported every frame, whatever the slot 1 tag says. A single-cycle strobe presents register read-return data from whichever codec the `rd_sel` input addresses.

Top module: `sdi_dual_frame_decoder`

## Requirements
- R1: After reset every output is 0. While no sync rising edge has started a frame, toggling the serial inputs changes no output.
- R2: The first bit of a frame is captured on the clock edge that follows the edge at which sync is first seen high after being low. A frame is a 16-bit tag slot followed by twelve 20-bit slots, all sent MSB first. After its 256th bit the decoder ignores the inputs until the next sync rise.
- R3: `codec_rdy[0]` is bit 15 of the primary tag slot and `codec_rdy[1]` is bit 15 of the secondary tag slot. Both are updated in the cycle after the last tag-slot bit is captured and hold otherwise.
- R4: `slot_tag[k-1]` (k = 1..12) is the OR of tag-slot bit 15-k of both lines. It is updated together with `codec_rdy`.
- R5: When line p flags slot k valid in the current frame, `slot_data[(k-1)*20 +: 20]` takes that slot's 20-bit word in the cycle after its last bit. A slot that neither line flags keeps its previous value.
- R6: If both lines flag the same data slot, the primary word is stored. `collide_err` goes to 1 the next cycle and stays at 1 until reset.
- R7: `slot_req` is the OR of bits 11:2 of slot 1 on both lines. It is updated every frame in the cycle after slot 1 ends, even when neither line sets the slot 1 tag, and holds otherwise.
- R8: When the line selected by `rd_sel` (0 = primary, 1 = secondary) flags both slot 1 and slot 2, `rd_valid` pulses for exactly one cycle after slot 2 ends. With it, `rd_addr` = bits 18:12 of that line's slot 1 and `rd_data` = bits 19:4 of that line's slot 2. No pulse occurs if the selected line lacks either tag, even if the other line has both.
- R9: A sync rise in the middle of a frame restarts capture at bit 0 of a new frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sync | input | 1 | Frame sync; a rising edge starts a frame |
| sdin_pri | input | 1 | Serial data from the primary codec |
| sdin_sec | input | 1 | Serial data from the secondary codec |
| rd_sel | input | 1 | Codec addressed by the pending read (0 primary, 1 secondary) |
| codec_rdy | output | 2 | Per-codec ready flags |
| slot_tag | output | 12 | Merged slot valid tags, bit k-1 for slot k |
| slot_data | output | 240 | Merged slot words, slot k at bits (k-1)*20 +: 20 |
| slot_req | output | 10 | Merged slot request bits |
| rd_valid | output | 1 | One-cycle strobe for read-return data |
| rd_addr | output | 7 | Register index of the read return |
| rd_data | output | 16 | Register data of the read return |
| collide_err | output | 1 | Sticky flag: both lines flagged one data slot |

## Verification
The bench sends back-to-back frames, frames separated by idle gaps with noise on the data lines, and a frame cut short by an early sync. A decoder whose counter is off by one bit would shift every slot word and fail on the first frame. A decoder that gated the request bits with the slot 1 tag would leave `slot_req` stale in a frame where only the request field is filled. Read returns are addressed both to the line that carries them and to the other line. A decoder that ORed the two lines' tags would strobe when it should stay silent. A collision frame checks that the primary word wins and that the error flag stays set afterwards.

// File: rtl/sdi_dec_pkg.sv
package sdi_dec_pkg;
  localparam int NLANE      = 2;
  localparam int TAG_W      = 16;
  localparam int SLOT_W     = 20;
  localparam int NSLOT      = 12;
  localparam int FRAME_BITS = TAG_W + NSLOT * SLOT_W;
  localparam int CNT_W      = $clog2(FRAME_BITS);
  localparam int SNUM_W     = $clog2(NSLOT + 1);
  localparam int REQ_W      = 10;
  localparam int ADDR_W     = 7;
  localparam int RDAT_W     = 16;

  // True when idx is the last bit of the tag slot or of a data slot
  function automatic logic is_slot_end(input logic [CNT_W-1:0] idx);
    int i;
    i = int'(idx);
    return (i == TAG_W - 1) || (i > TAG_W - 1 && ((i - (TAG_W - 1)) % SLOT_W) == 0);
  endfunction

  // Slot number holding bit idx (0 = tag slot)
  function automatic logic [SNUM_W-1:0] slot_of(input logic [CNT_W-1:0] idx);
    int i;
    i = int'(idx);
    if (i < TAG_W) return '0;
    return SNUM_W'((i - TAG_W) / SLOT_W + 1);
  endfunction

  // Valid flags for slots 1..NSLOT, taken from the tag word
  function automatic logic [NSLOT-1:0] tags_of(input logic [TAG_W-1:0] s0);
    logic [NSLOT-1:0] t;
    for (int k = 1; k <= NSLOT; k++) t[k-1] = s0[TAG_W-1-k];
    return t;
  endfunction
endpackage

// File: rtl/sdi_frame_timer.sv
module sdi_frame_timer
  import sdi_dec_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sync,
  output logic              sync_rise,
  output logic              bit_en,
  output logic [CNT_W-1:0]  bit_idx,
  output logic              slot_end,
  output logic [SNUM_W-1:0] slot_num
);
  logic sync_q;
  logic active;

  assign sync_rise = sync & ~sync_q;
  assign bit_en    = active;
  assign slot_end  = active && is_slot_end(bit_idx);
  assign slot_num  = slot_of(bit_idx);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q  <= 1'b0;
      active  <= 1'b0;
      bit_idx <= '0;
    end else begin
      sync_q <= sync;
      if (sync_rise) begin
        active  <= 1'b1;
        bit_idx <= '0;
      end else if (active) begin
        if (bit_idx == CNT_W'(FRAME_BITS - 1)) active <= 1'b0;
        bit_idx <= bit_idx + 1'b1;
      end
    end
  end
endmodule

// File: rtl/sdi_lane_shift.sv
module sdi_lane_shift
  import sdi_dec_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_en,
  input  logic              sdi,
  output logic [SLOT_W-1:0] word
);
  logic [SLOT_W-2:0] sh;

  // Word ending with the bit being captured this cycle
  assign word = {sh, sdi};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      sh <= '0;
    else if (bit_en) sh <= {sh[SLOT_W-3:0], sdi};
  end
endmodule

// File: rtl/sdi_slot_merge.sv
module sdi_slot_merge
  import sdi_dec_pkg::*;
(
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               slot_end,
  input  logic [SNUM_W-1:0]                  slot_num,
  input  logic [NLANE-1:0][SLOT_W-1:0]       words,
  input  logic                               rd_sel,
  output logic                               hit_pri,
  output logic                               hit_sec,
  output logic                               rd_fire,
  output logic [NLANE-1:0]                   codec_rdy,
  output logic [NSLOT-1:0]                   slot_tag,
  output logic [NSLOT-1:0][SLOT_W-1:0]       slot_data,
  output logic [REQ_W-1:0]                   slot_req,
  output logic                               rd_valid,
  output logic [ADDR_W-1:0]                  rd_addr,
  output logic [RDAT_W-1:0]                  rd_data,
  output logic                               collide_err
);
  logic [NLANE-1:0][NSLOT-1:0]  tag_q;
  logic [NLANE-1:0][ADDR_W-1:0] addr_q;
  logic [SNUM_W-1:0]            sidx;
  logic                         tag_end;
  logic                         s1_end;
  logic [NSLOT-1:0]             tag_or;
  logic [REQ_W-1:0]             req_or;

  assign sidx    = slot_num - SNUM_W'(1);
  assign tag_end = slot_end && (slot_num == '0);
  assign s1_end  = slot_end && (slot_num == SNUM_W'(1));
  assign hit_pri = slot_end && (slot_num != '0) && tag_q[0][sidx];
  assign hit_sec = slot_end && (slot_num != '0) && tag_q[1][sidx];
  assign rd_fire = slot_end && (slot_num == SNUM_W'(2)) && tag_q[rd_sel][0] && tag_q[rd_sel][1];

  always_comb begin
    tag_or = '0;
    req_or = '0;
    for (int l = 0; l < NLANE; l++) begin
      tag_or = tag_or | tags_of(words[l][TAG_W-1:0]);
      req_or = req_or | words[l][11:2];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tag_q       <= '0;
      addr_q      <= '0;
      codec_rdy   <= '0;
      slot_tag    <= '0;
      slot_data   <= '0;
      slot_req    <= '0;
      rd_valid    <= 1'b0;
      rd_addr     <= '0;
      rd_data     <= '0;
      collide_err <= 1'b0;
    end else begin
      rd_valid <= rd_fire;
      if (tag_end) begin
        slot_tag <= tag_or;
        for (int l = 0; l < NLANE; l++) begin
          tag_q[l]     <= tags_of(words[l][TAG_W-1:0]);
          codec_rdy[l] <= words[l][TAG_W-1];
        end
      end
      if (s1_end) begin
        slot_req <= req_or;
        for (int l = 0; l < NLANE; l++) addr_q[l] <= words[l][18:12];
      end
      if (hit_pri)      slot_data[sidx] <= words[0];
      else if (hit_sec) slot_data[sidx] <= words[1];
      if (hit_pri && hit_sec) collide_err <= 1'b1;
      if (rd_fire) begin
        rd_addr <= addr_q[rd_sel];
        rd_data <= words[rd_sel][SLOT_W-1:SLOT_W-RDAT_W];
      end
    end
  end
endmodule

// File: rtl/sdi_dual_frame_decoder.sv
module sdi_dual_frame_decoder
  import sdi_dec_pkg::*;
(
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      sync,
  input  logic                      sdin_pri,
  input  logic                      sdin_sec,
  input  logic                      rd_sel,
  output logic [NLANE-1:0]          codec_rdy,
  output logic [NSLOT-1:0]          slot_tag,
  output logic [NSLOT*SLOT_W-1:0]   slot_data,
  output logic [REQ_W-1:0]          slot_req,
  output logic                      rd_valid,
  output logic [ADDR_W-1:0]         rd_addr,
  output logic [RDAT_W-1:0]         rd_data,
  output logic                      collide_err
);
  logic                          sync_rise;
  logic                          bit_en;
  logic [CNT_W-1:0]              bit_idx;
  logic                          slot_end;
  logic [SNUM_W-1:0]             slot_num;
  logic                          hit_pri;
  logic                          hit_sec;
  logic                          rd_fire;
  logic [NLANE-1:0]              sdin;
  logic [NLANE-1:0][SLOT_W-1:0]  words;
  logic [NSLOT-1:0][SLOT_W-1:0]  data_arr;

  assign sdin      = {sdin_sec, sdin_pri};
  assign slot_data = data_arr;

  sdi_frame_timer u_timer (
    .clk(clk), .rst_n(rst_n), .sync(sync), .sync_rise(sync_rise),
    .bit_en(bit_en), .bit_idx(bit_idx), .slot_end(slot_end), .slot_num(slot_num)
  );

  for (genvar l = 0; l < NLANE; l++) begin : g_lane
    sdi_lane_shift u_shift (
      .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .sdi(sdin[l]), .word(words[l])
    );
  end

  sdi_slot_merge u_merge (
    .clk(clk), .rst_n(rst_n), .slot_end(slot_end), .slot_num(slot_num),
    .words(words), .rd_sel(rd_sel), .hit_pri(hit_pri), .hit_sec(hit_sec),
    .rd_fire(rd_fire), .codec_rdy(codec_rdy), .slot_tag(slot_tag),
    .slot_data(data_arr), .slot_req(slot_req), .rd_valid(rd_valid),
    .rd_addr(rd_addr), .rd_data(rd_data), .collide_err(collide_err)
  );
endmodule

// File: rtl/sdi_dec_checker.sv
module sdi_dec_checker
  import sdi_dec_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              sync_rise,
  input logic              bit_en,
  input logic              slot_end,
  input logic [SNUM_W-1:0] slot_num,
  input logic              hit_pri,
  input logic              hit_sec,
  input logic [NLANE-1:0]  codec_rdy,
  input logic [NSLOT-1:0]  slot_tag,
  input logic [REQ_W-1:0]  slot_req,
  input logic              rd_valid,
  input logic              collide_err
);
  assert_first_bit_R2: assert property (@(posedge clk) disable iff (!rst_n)
    sync_rise |=> (bit_en && !slot_end));

  assert_rdy_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(slot_end && slot_num == '0) |=> $stable(codec_rdy));

  assert_tag_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(slot_end && slot_num == '0) |=> $stable(slot_tag));

  assert_collide_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_pri && hit_sec) |=> collide_err);

  assert_collide_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    collide_err |=> collide_err);

  assert_req_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(slot_end && slot_num == SNUM_W'(1)) |=> $stable(slot_req));

  assert_rd_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> !rd_valid);

  assert_rd_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(slot_end && slot_num == SNUM_W'(2)));
endmodule

bind sdi_dual_frame_decoder sdi_dec_checker u_chk (
  .clk(clk), .rst_n(rst_n), .sync_rise(sync_rise), .bit_en(bit_en),
  .slot_end(slot_end), .slot_num(slot_num), .hit_pri(hit_pri), .hit_sec(hit_sec),
  .codec_rdy(codec_rdy), .slot_tag(slot_tag), .slot_req(slot_req),
  .rd_valid(rd_valid), .collide_err(collide_err)
);

// File: tb/tb_sdi_dual_frame_decoder.sv
module tb_sdi_dual_frame_decoder;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sync = 1'b0, sdin_pri = 1'b0, sdin_sec = 1'b0, rd_sel = 1'b0;
  logic [1:0]   codec_rdy;
  logic [11:0]  slot_tag;
  logic [239:0] slot_data;
  logic [9:0]   slot_req;
  logic         rd_valid;
  logic [6:0]   rd_addr;
  logic [15:0]  rd_data;
  logic         collide_err;

  always #2 clk = ~clk;

  sdi_dual_frame_decoder dut (
    .clk(clk), .rst_n(rst_n), .sync(sync), .sdin_pri(sdin_pri), .sdin_sec(sdin_sec),
    .rd_sel(rd_sel), .codec_rdy(codec_rdy), .slot_tag(slot_tag), .slot_data(slot_data),
    .slot_req(slot_req), .rd_valid(rd_valid), .rd_addr(rd_addr), .rd_data(rd_data),
    .collide_err(collide_err)
  );

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  // Frame contents to send: tag word and 12 slot words per line
  logic [15:0] fr_s0 [2];
  logic [19:0] fr_sl [2][1:12];

  // Reference model state
  logic [1:0]  m_rdy = '0;
  logic [11:0] m_tag = '0;
  logic [19:0] m_data [1:12];
  logic [9:0]  m_req = '0;
  logic        m_rdv = 0, m_col = 0;
  logic [6:0]  m_addr = '0;
  logic [15:0] m_rdat = '0;
  logic [15:0] cur_s0 [2];
  logic [19:0] cur_s1 [2];

  task automatic chk(input string req, input string nm, input logic [239:0] act, input logic [239:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, nm, act, exp);
    end
  endtask

  task automatic compare_all(input string req);
    logic [239:0] flat;
    for (int k = 1; k <= 12; k++) flat[(k-1)*20 +: 20] = m_data[k];
    chk({req, "/R3"}, "codec_rdy", 240'(codec_rdy), 240'(m_rdy));
    chk({req, "/R4"}, "slot_tag", 240'(slot_tag), 240'(m_tag));
    chk({req, "/R5"}, "slot_data", slot_data, flat);
    chk({req, "/R7"}, "slot_req", 240'(slot_req), 240'(m_req));
    chk({req, "/R8"}, "rd_valid", 240'(rd_valid), 240'(m_rdv));
    chk({req, "/R8"}, "rd_addr", 240'(rd_addr), 240'(m_addr));
    chk({req, "/R8"}, "rd_data", 240'(rd_data), 240'(m_rdat));
    chk({req, "/R6"}, "collide_err", 240'(collide_err), 240'(m_col));
  endtask

  function automatic logic bit_at(input int lane, input int b);
    int k, pos;
    if (b < 16) return fr_s0[lane][15-b];
    k = (b - 16) / 20 + 1;
    pos = 19 - ((b - 16) % 20);
    return fr_sl[lane][k][pos];
  endfunction

  // Model update for bit b captured at the last edge
  task automatic model_bit(input int b, input logic sel);
    m_rdv = 0;
    if (b == 15) begin
      for (int l = 0; l < 2; l++) begin
        cur_s0[l] = fr_s0[l];
        m_rdy[l] = fr_s0[l][15];
      end
      for (int k = 1; k <= 12; k++) m_tag[k-1] = cur_s0[0][15-k] | cur_s0[1][15-k];
    end else if (b > 15 && (b - 15) % 20 == 0) begin
      int k;
      logic v0, v1;
      k = (b - 15) / 20;
      v0 = cur_s0[0][15-k];
      v1 = cur_s0[1][15-k];
      if (v0) m_data[k] = fr_sl[0][k];
      else if (v1) m_data[k] = fr_sl[1][k];
      if (v0 && v1) m_col = 1;
      if (k == 1) begin
        m_req = fr_sl[0][1][11:2] | fr_sl[1][1][11:2];
        for (int l = 0; l < 2; l++) cur_s1[l] = fr_sl[l][1];
      end
      if (k == 2 && cur_s0[sel][14] && cur_s0[sel][13]) begin
        m_rdv = 1;
        m_addr = cur_s1[sel][18:12];
        m_rdat = fr_sl[sel][2][19:4];
      end
    end
  endtask

  task automatic clear_frame();
    for (int l = 0; l < 2; l++) begin
      fr_s0[l] = '0;
      for (int k = 1; k <= 12; k++) fr_sl[l][k] = 20'($urandom);
    end
  endtask

  task automatic put_slot(input int lane, input int k, input logic [19:0] v);
    fr_sl[lane][k] = v;
    fr_s0[lane][15-k] = 1'b1;
  endtask

  // Sync-only lead cycle that starts the first frame of a burst (R2)
  task automatic lead();
    sync = 1; sdin_pri = 0; sdin_sec = 0;
    @(posedge clk);
    m_rdv = 0;
    @(negedge clk);
    compare_all("R2");
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      sync = 0; sdin_pri = 1'($urandom); sdin_sec = 1'($urandom);
      @(posedge clk);
      m_rdv = 0;
      @(negedge clk);
      compare_all("R1");
    end
  endtask

  // Send nbits of the prepared frame; raise sync on the last bit if more follows
  task automatic send_frame(input logic sel, input int nbits, input bit more, input string req);
    for (int b = 0; b < nbits; b++) begin
      sdin_pri = bit_at(0, b);
      sdin_sec = bit_at(1, b);
      sync = (b < 15) || (more && b == nbits - 1);
      rd_sel = sel;
      @(posedge clk);
      model_bit(b, sel);
      @(negedge clk);
      compare_all(req);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    for (int k = 1; k <= 12; k++) m_data[k] = '0;
    for (int l = 0; l < 2; l++) begin cur_s0[l] = '0; cur_s1[l] = '0; end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    compare_all("R1");
    idle(40);

    // Frame A: primary read return, secondary on slots 6/7, requests on both
    clear_frame();
    fr_s0[0][15] = 1;
    put_slot(0, 1, 20'h2A5F4);
    put_slot(0, 2, 20'hBEEF0);
    put_slot(0, 3, 20'h13579);
    put_slot(0, 4, 20'hFFFFF);
    put_slot(1, 6, 20'h0A0A0);
    put_slot(1, 7, 20'h5555A);
    fr_sl[1][1] = 20'h00804;
    lead();
    send_frame(0, 256, 1, "R5");

    // Frame B: requests only on primary slot 1 with no tag; secondary read return
    clear_frame();
    fr_s0[1][15] = 1;
    fr_sl[0][1] = 20'h7F3FC;
    put_slot(1, 1, 20'h54000);
    put_slot(1, 2, 20'hC0DE5);
    put_slot(0, 12, 20'h12345);
    send_frame(1, 256, 1, "R7");

    // Frame C: primary has both tags but secondary is addressed: no strobe
    clear_frame();
    fr_s0[0][15] = 1; fr_s0[1][15] = 1;
    put_slot(0, 1, 20'h11111);
    put_slot(0, 2, 20'h22222);
    put_slot(1, 5, 20'h98765);
    send_frame(1, 256, 1, "R8");

    // Frame D: collision on slot 3; primary word must win
    clear_frame();
    put_slot(0, 3, 20'hAAAAA);
    put_slot(1, 3, 20'h55555);
    put_slot(1, 8, 20'h0F0F0);
    send_frame(0, 256, 1, "R6");

    // Frame E: cut short at bit 100 by an early sync rise
    clear_frame();
    put_slot(1, 2, 20'h3C3C3);
    send_frame(0, 100, 1, "R9");

    // Frame F: full frame after the restart
    clear_frame();
    fr_s0[1][15] = 1;
    put_slot(1, 1, 20'h7E001);
    put_slot(1, 2, 20'hFACE0);
    put_slot(0, 9, 20'h44444);
    send_frame(1, 256, 0, "R9");
    idle(30);

    // Random frames with disjoint slot ownership
    for (int f = 0; f < 6; f++) begin
      clear_frame();
      fr_s0[0][15] = 1'($urandom);
      fr_s0[1][15] = 1'($urandom);
      for (int k = 1; k <= 12; k++) begin
        int own;
        own = int'($urandom % 3);
        if (own < 2) put_slot(own, k, 20'($urandom));
      end
      lead();
      send_frame(1'($urandom), 256, 0, "R2");
      idle(5);
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule